// File: doc/BRIEF.md
# Accumulator Machine Execution Sequencer

This block is the control core of a small single-accumulator processor. It keeps the program counter, the accumulator, an instruction register and two condition flags (zero and negative). It steps through a fetch, decode/execute and, when needed, operand-read sequence against a synchronous, word-addressed RAM that holds both code and data. Arithmetic and logic work goes to an external combinational ALU: the core presents the opcode and both operands, then captures the result and the flags it implies.

After reset the core is stopped. While stopped, an external port may overwrite the program counter to pick the next instruction. A start pulse then runs from that address. A halt instruction stops the core again, with the program counter pointing at the word after the halt, so a later start resumes from there.

Top module: `acc_seq_core`

## Requirements
- R1: After reset the core is stopped (`halted`=1), with `pc`=0, `acc`=0, `flag_z`=0 and `flag_n`=0, and it issues no memory access while stopped.
- R2: While stopped, `pc_wr_en` loads `pc_wr_data` into `pc`. While running, `pc_wr_en` has no effect.
- R3: A `start` pulse while stopped begins fetching at the current `pc`. A `start` while running has no effect.
- R4: An instruction word carries the opcode in bits [15:12], the immediate flag in bit 11 and the operand in bits [7:0]. Bits [10:8] are ignored. Opcodes are: 0 NOP, 1 LOD, 2 STO, 3 JMP, 4 JZ, 5 JNZ, 6 JN, 7 JNN, 8 ADD, 9 SUB, A MUL, B DIV, C AND, D CMP, E NOT, F HLT.
- R5: LOD with the immediate flag set puts the zero-extended operand into `acc`. With the flag clear it puts RAM[operand] into `acc`. LOD leaves both flags unchanged.
- R6: STO writes `acc` to RAM[operand] whatever the immediate flag, and leaves `acc` and the flags unchanged.
- R7: For opcodes 8 to E the core drives `alu_op`=opcode, `alu_a`=`acc` and `alu_b`=operand value (immediate or RAM[operand]), with `alu_req` high for one cycle. It then sets `flag_z`=(`alu_y`==0) and `flag_n`=`alu_y`[15]. It also loads `alu_y` into `acc` for every one of these opcodes except CMP, which leaves `acc` unchanged.
- R8: JMP always loads the operand into `pc`. JZ/JNZ jump when Z is set/clear, and JN/JNN jump when N is set/clear. A jump that is not taken advances `pc` by one.
- R9: NOP only advances `pc`. HLT advances `pc` and stops the core (`halted`=1).
- R10: Each instruction takes two cycles, plus one extra cycle for a LOD or ALU instruction in direct mode. A STO takes two cycles.
- R11: `pc` wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Leave the stopped state |
| pc_wr_en | input | 1 | Load the program counter while stopped |
| pc_wr_data | input | 8 | Value for the program counter |
| mem_addr | output | 8 | RAM word address |
| mem_rd_en | output | 1 | RAM read; data appears the next cycle |
| mem_wr_en | output | 1 | RAM write |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data |
| alu_req | output | 1 | ALU result is captured this cycle |
| alu_op | output | 4 | Operation for the ALU (the opcode) |
| alu_a | output | 16 | ALU first operand (accumulator) |
| alu_b | output | 16 | ALU second operand |
| alu_y | input | 16 | ALU result |
| halted | output | 1 | Core is stopped |
| pc | output | 8 | Program counter |
| acc | output | 16 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The hardest case to reach from the ports is the claim that a program-counter write or a start pulse does nothing while the core runs. That stimulus has to land in the middle of a program. The bench injects both strobes a few cycles into a run and uses a target that would divert the program onto a halt if the strobes were obeyed. It then compares the store, the final registers and the cycle count against the undisturbed outcome. Flag preservation by loads is brought out by setting Z with a subtraction, taking a branch on it, and then ending with a direct load whose value is non-zero.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_LOD = 4'h1, OP_STO = 4'h2, OP_JMP = 4'h3,
    OP_JZ  = 4'h4, OP_JNZ = 4'h5, OP_JN  = 4'h6, OP_JNN = 4'h7,
    OP_ADD = 4'h8, OP_SUB = 4'h9, OP_MUL = 4'hA, OP_DIV = 4'hB,
    OP_AND = 4'hC, OP_CMP = 4'hD, OP_NOT = 4'hE, OP_HLT = 4'hF
  } opc_t;

  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_OPRD  = 2'd3
  } state_t;

  localparam int OPC_W = 4;

  function automatic logic op_is_alu(input opc_t op);
    return op[3] && (op != OP_HLT);
  endfunction

  function automatic logic op_is_jump(input opc_t op);
    return (op == OP_JMP) || (op[3:2] == 2'b01);
  endfunction

  function automatic logic jump_ok(input opc_t op, input logic z, input logic n);
    case (op)
      OP_JMP:  return 1'b1;
      OP_JZ:   return z;
      OP_JNZ:  return !z;
      OP_JN:   return n;
      OP_JNN:  return !n;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic [DW-1:0] word,
  output opc_t          op,
  output logic          imm,
  output logic [AW-1:0] operand,
  output logic          is_load,
  output logic          is_store,
  output logic          is_alu,
  output logic          is_jump,
  output logic          is_halt,
  output logic          needs_read
);
  localparam int OPC_LSB = DW - OPC_W;
  localparam int IMM_BIT = OPC_LSB - 1;

  logic unused_rsvd;
  assign unused_rsvd = ^word[IMM_BIT-1:AW];

  assign op       = opc_t'(word[DW-1:OPC_LSB]);
  assign imm      = word[IMM_BIT];
  assign operand  = word[AW-1:0];
  assign is_load  = (op == OP_LOD);
  assign is_store = (op == OP_STO);
  assign is_alu   = op_is_alu(op);
  assign is_jump  = op_is_jump(op);
  assign is_halt  = (op == OP_HLT);
  assign needs_read = !imm && (is_load || is_alu);
endmodule

// File: rtl/acc_branch.sv
module acc_branch
  import acc_pkg::*;
(
  input  opc_t op,
  input  logic z,
  input  logic n,
  output logic take
);
  assign take = jump_ok(op, z, n);
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pc_wr_en,
  input  logic [AW-1:0] pc_wr_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          alu_req,
  output logic [3:0]    alu_op,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  input  logic [DW-1:0] alu_y,
  output logic          halted,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic          flag_z,
  output logic          flag_n
);
  localparam int PADW = DW - AW;

  state_t        state;
  logic [DW-1:0] ir;

  logic [DW-1:0] cur_word;
  opc_t          dec_op;
  logic          dec_imm, dec_load, dec_store, dec_alu, dec_jump, dec_halt, dec_rd;
  logic [AW-1:0] dec_operand;
  logic          br_take;

  assign cur_word = (state == ST_OPRD) ? ir : mem_rdata;

  acc_decode #(.DW(DW), .AW(AW)) u_dec (
    .word(cur_word), .op(dec_op), .imm(dec_imm), .operand(dec_operand),
    .is_load(dec_load), .is_store(dec_store), .is_alu(dec_alu),
    .is_jump(dec_jump), .is_halt(dec_halt), .needs_read(dec_rd)
  );

  acc_branch u_br (.op(dec_op), .z(flag_z), .n(flag_n), .take(br_take));

  // named events for the checker
  logic          in_exec, exec_now;
  logic          jump_fire, load_fire, alu_fire, store_fire, halt_fire;
  logic [AW-1:0] jump_target, pc_next;
  logic [DW-1:0] load_val;

  assign in_exec     = (state == ST_EXEC);
  assign exec_now    = (in_exec && !dec_rd) || (state == ST_OPRD);
  assign jump_fire   = in_exec && dec_jump && br_take;
  assign jump_target = dec_operand;
  assign load_fire   = exec_now && dec_load;
  assign alu_fire    = exec_now && dec_alu;
  assign store_fire  = in_exec && dec_store;
  assign halt_fire   = in_exec && dec_halt;
  assign load_val    = (state == ST_OPRD) ? mem_rdata : {{PADW{1'b0}}, dec_operand};
  assign pc_next     = jump_fire ? jump_target : pc + AW'(1);

  assign mem_rd_en = (state == ST_FETCH) || (in_exec && dec_rd);
  assign mem_wr_en = store_fire;
  assign mem_addr  = (state == ST_FETCH) ? pc : dec_operand;
  assign mem_wdata = acc;

  assign alu_req = alu_fire;
  assign alu_op  = dec_op;
  assign alu_a   = acc;
  assign alu_b   = load_val;

  assign halted = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_HALT;
      pc     <= '0;
      acc    <= '0;
      ir     <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      case (state)
        ST_HALT: begin
          if (pc_wr_en) pc <= pc_wr_data;
          if (start) state <= ST_FETCH;
        end
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          ir <= mem_rdata;
          pc <= pc_next;
          if (halt_fire)   state <= ST_HALT;
          else if (dec_rd) state <= ST_OPRD;
          else             state <= ST_FETCH;
        end
        ST_OPRD: state <= ST_FETCH;
        default: state <= ST_HALT;
      endcase
      if (load_fire) acc <= load_val;
      if (alu_fire) begin
        if (dec_op != OP_CMP) acc <= alu_y;
        flag_z <= (alu_y == '0);
        flag_n <= alu_y[DW-1];
      end
    end
  end
endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          pc_wr_en,
  input logic          halted,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic          flag_z,
  input logic          flag_n,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic          alu_req,
  input logic [3:0]    alu_op,
  input logic [DW-1:0] alu_y,
  input logic          jump_fire,
  input logic [AW-1:0] jump_target,
  input logic          load_fire,
  input logic [DW-1:0] load_val
);
  assert_quiet_when_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd_en && !mem_wr_en));

  assert_pc_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !pc_wr_en) |=> $stable(pc));

  assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && start) |=> !halted);

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (acc == $past(load_val)) && $stable(flag_z) && $stable(flag_n));

  assert_store_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> $stable(acc) && $stable(flag_z) && $stable(flag_n));

  assert_alu_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alu_req |=> (flag_z == ($past(alu_y) == '0)) && (flag_n == $past(alu_y[DW-1])));

  assert_cmp_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_req && alu_op == 4'hD) |=> $stable(acc));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_fire |=> (pc == $past(jump_target)));

  assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
endmodule

bind acc_seq_core acc_seq_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pc_wr_en(pc_wr_en),
  .halted(halted), .pc(pc), .acc(acc), .flag_z(flag_z), .flag_n(flag_n),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .alu_req(alu_req),
  .alu_op(alu_op), .alu_y(alu_y), .jump_fire(jump_fire),
  .jump_target(jump_target), .load_fire(load_fire), .load_val(load_val)
);

// File: tb/acc_seq_core_tb.sv
module acc_seq_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        pc_wr_en = 0;
  logic [7:0]  pc_wr_data = 0;
  logic [7:0]  mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        alu_req;
  logic [3:0]  alu_op;
  logic [15:0] alu_a, alu_b;
  logic [15:0] alu_y;
  logic        halted;
  logic [7:0]  pc;
  logic [15:0] acc;
  logic        flag_z, flag_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  acc_seq_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_wr_en(pc_wr_en),
    .pc_wr_data(pc_wr_data), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .alu_req(alu_req), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .alu_y(alu_y), .halted(halted), .pc(pc), .acc(acc),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  // RAM model: synchronous read, one cycle latency
  logic [15:0] ram [256];
  always @(posedge clk) begin
    if (mem_wr_en) ram[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= ram[mem_addr];
  end

  // ALU model written from R7
  always_comb begin
    case (alu_op)
      4'h8: alu_y = alu_a + alu_b;
      4'h9: alu_y = alu_a - alu_b;
      4'hA: alu_y = alu_a * alu_b;
      4'hB: alu_y = (alu_b == 0) ? 16'hFFFF : alu_a / alu_b;
      4'hC: alu_y = alu_a & alu_b;
      4'hD: alu_y = alu_a - alu_b;
      4'hE: alu_y = ~alu_b;
      default: alu_y = 16'h0000;
    endcase
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic im, input logic [7:0] x);
    return {op, im, 3'b000, x};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard of expected RAM writes
  logic [23:0] exp_st [$];
  task automatic expect_store(input logic [7:0] a, input logic [15:0] d);
    exp_st.push_back({a, d});
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (exp_st.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected store: actual %0h:%0h expected none", mem_addr, mem_wdata);
      end else begin
        logic [23:0] e;
        e = exp_st.pop_front();
        check("R6", "store addr", int'(mem_addr), int'(e[23:16]));
        check("R6", "store data", int'(mem_wdata), int'(e[15:0]));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected halt");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic set_pc(input logic [7:0] v);
    pc_wr_en = 1; pc_wr_data = v;
    @(negedge clk);
    pc_wr_en = 0;
  endtask

  // start, then count running cycles; optional disturbance at cycle 3
  task automatic run(input string req, input int exp_cyc, input bit disturb);
    int cnt;
    start = 1;
    @(negedge clk);
    start = 0;
    cnt = 0;
    while (!halted && cnt < 2000) begin
      cnt++;
      if (disturb && cnt == 3) begin pc_wr_en = 1; pc_wr_data = 8'h34; start = 1; end
      else begin pc_wr_en = 0; start = 0; end
      @(negedge clk);
    end
    pc_wr_en = 0; start = 0;
    check(req, "cycle count", cnt, exp_cyc);
    check(req, "store queue drained", exp_st.size(), 0);
  endtask

  task automatic final_state(input string req, input logic [15:0] a, input logic z,
                             input logic n, input logic [7:0] p);
    check(req, "acc", int'(acc), int'(a));
    check(req, "flag_z", int'(flag_z), int'(z));
    check(req, "flag_n", int'(flag_n), int'(n));
    check(req, "pc", int'(pc), int'(p));
    check(req, "halted", int'(halted), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = ins(4'hF, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "halted", int'(halted), 1);
    check("R1", "pc", int'(pc), 0);
    check("R1", "acc", int'(acc), 0);
    check("R1", "flags", int'({flag_z, flag_n}), 0);
    check("R1", "no mem access", int'({mem_rd_en, mem_wr_en}), 0);

    // Program A: loads, store, Z branch, direct load keeps flags (R5 R6 R8 R10)
    ram[0] = ins(4'h1, 1, 8'd5);
    ram[1] = ins(4'h8, 1, 8'd3);
    ram[2] = ins(4'h2, 0, 8'h80);
    ram[3] = ins(4'h9, 1, 8'd8);
    ram[4] = ins(4'h4, 0, 8'd6);
    ram[5] = ins(4'h1, 1, 8'd99);
    ram[6] = ins(4'h1, 0, 8'h80);
    ram[7] = ins(4'hF, 0, 0);
    expect_store(8'h80, 16'd8);
    run("R10", 15, 0);
    final_state("R5", 16'd8, 1, 0, 8'd8);

    // Program B at 0x10: N branches, CMP, MUL, AND, NOT, STO imm flag (R2 R7 R8 R9)
    set_pc(8'h10);
    check("R2", "pc load while stopped", int'(pc), 'h10);
    ram[8'h10] = ins(4'h1, 1, 8'd1);
    ram[8'h11] = ins(4'h9, 1, 8'd2);
    ram[8'h12] = ins(4'h6, 0, 8'h15);
    ram[8'h13] = ins(4'hF, 0, 0);
    ram[8'h14] = ins(4'hF, 0, 0);
    ram[8'h15] = ins(4'h7, 0, 8'h13);
    ram[8'h16] = ins(4'h5, 0, 8'h18);
    ram[8'h17] = ins(4'hF, 0, 0);
    ram[8'h18] = ins(4'hD, 1, 8'd0);
    ram[8'h19] = ins(4'hA, 1, 8'd2);
    ram[8'h1A] = ins(4'hC, 1, 8'h0F);
    ram[8'h1B] = ins(4'h4, 0, 8'h13);
    ram[8'h1C] = ins(4'h7, 0, 8'h1E);
    ram[8'h1D] = ins(4'hF, 0, 0);
    ram[8'h1E] = ins(4'hE, 1, 8'h00);
    ram[8'h1F] = ins(4'h2, 1, 8'h81);
    ram[8'h20] = ins(4'hF, 0, 0);
    expect_store(8'h81, 16'hFFFF);
    run("R8", 26, 0);
    final_state("R7", 16'hFFFF, 0, 1, 8'h21);

    // Program D: resume after HLT without a pc write (R3 R9)
    ram[8'h21] = ins(4'h1, 1, 8'h42);
    ram[8'h22] = ins(4'hF, 0, 0);
    run("R3", 4, 0);
    final_state("R9", 16'h0042, 0, 1, 8'h23);

    // Program C at 0x30: direct ALU operands, DIV, JMP, reserved bits,
    // with pc write and start injected while running (R2 R3 R4 R10)
    set_pc(8'h30);
    ram[8'h90] = 16'd100;
    ram[8'h91] = 16'd7;
    ram[8'h92] = 16'hFFF2;
    ram[8'h30] = ins(4'h1, 0, 8'h90);
    ram[8'h31] = ins(4'hB, 0, 8'h91);
    ram[8'h32] = ins(4'h8, 0, 8'h92);
    ram[8'h33] = ins(4'h3, 0, 8'h36);
    ram[8'h34] = ins(4'hF, 0, 0);
    ram[8'h35] = ins(4'hF, 0, 0);
    ram[8'h36] = ins(4'h2, 0, 8'h93) | 16'h0700;
    ram[8'h37] = ins(4'hF, 0, 0);
    expect_store(8'h93, 16'h0000);
    run("R2", 15, 1);
    final_state("R4", 16'h0000, 1, 0, 8'h38);
    check("R4", "RAM after reserved-bit store", int'(ram[8'h93]), 0);

    // Wrap: pc 0xFF -> 0x00 (R11)
    ram[8'hFF] = ins(4'h1, 1, 8'd7);
    ram[8'h00] = ins(4'hF, 0, 0);
    set_pc(8'hFF);
    run("R11", 4, 0);
    final_state("R11", 16'd7, 1, 0, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule